// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps the local time for an Ethernet MAC that timestamps precision time protocol traffic. The time has a seconds count, a nanoseconds count that always stays below one billion, and a hidden 24-bit fraction of a nanosecond. On every clock the block adds a programmable step to this time. The step is a small whole-nanosecond amount plus a 24-bit fraction. A servo running in software trims the clock frequency by changing that step.

Software reaches the block through a simple 32-bit word bus. The writes and reads are single-cycle strobes, and read data comes back registered. Software can program the step and place a complete time in one atomic load. It can take a coherent snapshot of the time across three words, and it can apply a one-shot signed offset. Four capture slots record the seconds-low and nanoseconds values when the MAC pulses a strobe: tx event, rx event, tx peer event and rx peer event, in that order.

Top module: `ptp_tod_counter`

## Requirements
- R1: On each clock with no time load and no offset write, the fraction gains the fractional step and the nanoseconds gain the whole step. A carry out of the 24-bit fraction adds one more nanosecond.
- R2: The nanoseconds value stays below 1,000,000,000. When a step reaches or passes that value, one billion is removed and the seconds go up by one in the same cycle. The 48-bit seconds count wraps from all ones to zero.
- R3: Word 1 is the fractional step, and its layout is scrambled. Register bits [15:0] hold fraction bits [23:8], and register bits [31:24] hold fraction bits [7:0]. Register bits [23:16] are ignored on write and read back as zero.
- R4: Word 0 is the whole-nanosecond step, 8 bits in [7:0]. After reset it reads 4, the fractional step reads 0, and the time is zero.
- R5: Writes to word 2 (seconds high, bits [15:0]) and word 3 (seconds low) only stage a value. The running seconds do not change until word 4 is written.
- R6: A write to word 4 loads, in one cycle, the staged seconds together with bits [29:0] as nanoseconds, and it clears the fraction. If the nanoseconds value is at least one billion, one billion is subtracted first.
- R7: A read of word 3 returns the live seconds-low value and, in the same cycle, freezes the seconds high and nanoseconds into a shadow. Later reads of word 2 and word 4 return that shadow.
- R8: A write to word 5 applies a one-time offset instead of that cycle's step. Bit 31 set means subtract. Bits [29:0] are a magnitude in nanoseconds, and it may be one billion or more. The seconds borrow or carry as needed, and the fraction is left unchanged.
- R9: Capture strobe bit k stores the time present before that clock edge into slot k. Word 8+2k reads its seconds low, and word 9+2k reads its nanoseconds. Slot 0 is tx event, 1 is rx event, 2 is tx peer, 3 is rx peer.
- R10: Read data shows up on the clock after the read strobe. Words 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_strobe | input | N_CAP | One capture request per slot |

## Verification
The counter runs under several step patterns:
- a whole step of 1 with a half-nanosecond fraction, which shows that the fraction carry is counted;
- the reset step of 4, run up to the nanosecond rollover and to the 48-bit seconds wrap;
- random steps with random scrambled fractions, which exercise the bit packing.

Offsets are tried in both directions, with magnitudes below and above one second. This separates a plain borrow or carry from a borrow or carry that also takes a whole second. Each time load is followed by a read of the staged seconds. The snapshot reads are spaced with random idle gaps, so a live value and a frozen one give different results.

// File: rtl/ptp_tod_pkg.sv
`timescale 1ns/1ps
package ptp_tod_pkg;
   localparam int unsigned NS_PER_SEC = 1_000_000_000;
   localparam int unsigned NS_W       = 30;
   localparam int unsigned ADDR_W     = 4;

   localparam logic [ADDR_W-1:0] A_INC_NS  = 4'd0;
   localparam logic [ADDR_W-1:0] A_INC_SUB = 4'd1;
   localparam logic [ADDR_W-1:0] A_SEC_HI  = 4'd2;
   localparam logic [ADDR_W-1:0] A_SEC_LO  = 4'd3;
   localparam logic [ADDR_W-1:0] A_NS      = 4'd4;
   localparam logic [ADDR_W-1:0] A_ADJ     = 4'd5;

   // scrambled fractional step: reg[15:0] = frac[23:8], reg[31:24] = frac[7:0]
   function automatic logic [23:0] sub_unpack(input logic [31:0] w);
      return {w[15:0], w[31:24]};
   endfunction

   function automatic logic [31:0] sub_pack(input logic [23:0] f);
      return {f[7:0], 8'h00, f[23:8]};
   endfunction
endpackage

// File: rtl/ptp_tod_incr.sv
`timescale 1ns/1ps
module ptp_tod_incr
   import ptp_tod_pkg::*;
#(
   parameter int unsigned INC_W  = 8,
   parameter int unsigned FRAC_W = 24,
   parameter logic [INC_W-1:0]  RST_INC_NS   = 4,
   parameter logic [FRAC_W-1:0] RST_INC_FRAC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ns,
   input  logic              wr_sub,
   input  logic [31:0]       wdata,
   output logic [INC_W-1:0]  inc_ns,
   output logic [FRAC_W-1:0] inc_frac
);
   logic unused_incr;
   assign unused_incr = ^wdata[23:16];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inc_ns   <= RST_INC_NS;
         inc_frac <= RST_INC_FRAC;
      end else begin
         if (wr_ns)  inc_ns   <= wdata[INC_W-1:0];
         if (wr_sub) inc_frac <= sub_unpack(wdata);
      end
   end
endmodule

// File: rtl/ptp_tod_core.sv
`timescale 1ns/1ps
module ptp_tod_core
   import ptp_tod_pkg::*;
#(
   parameter int unsigned SEC_W  = 48,
   parameter int unsigned INC_W  = 8,
   parameter int unsigned FRAC_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INC_W-1:0]  inc_ns,
   input  logic [FRAC_W-1:0] inc_frac,
   input  logic              load_en,
   input  logic [SEC_W-1:0]  load_sec,
   input  logic [NS_W-1:0]   load_ns,
   input  logic              adj_en,
   input  logic              adj_neg,
   input  logic [NS_W-1:0]   adj_mag,
   output logic [SEC_W-1:0]  tod_sec,
   output logic [NS_W-1:0]   tod_ns,
   output logic [FRAC_W-1:0] tod_frac
);
   localparam logic [31:0] BILLION = 32'(NS_PER_SEC);

   logic [FRAC_W:0] frac_sum;
   logic [31:0] ns_sum, ns_wrap, mag_ns, add_sum, add_fix, sub_fix, ld_fix;
   logic tick_wrap, mag_big, add_wrap, sub_borrow;
   logic [SEC_W-1:0]  sec_nxt;
   logic [NS_W-1:0]   ns_nxt;
   logic [FRAC_W-1:0] frac_nxt;

   always_comb begin
      // regular step
      frac_sum  = {1'b0, tod_frac} + {1'b0, inc_frac};
      ns_sum    = 32'(tod_ns) + 32'(inc_ns) + 32'(frac_sum[FRAC_W]);
      tick_wrap = ns_sum >= BILLION;
      ns_wrap   = tick_wrap ? ns_sum - BILLION : ns_sum;
      // one-shot offset: split into whole second and remainder
      mag_big    = 32'(adj_mag) >= BILLION;
      mag_ns     = mag_big ? 32'(adj_mag) - BILLION : 32'(adj_mag);
      add_sum    = 32'(tod_ns) + mag_ns;
      add_wrap   = add_sum >= BILLION;
      add_fix    = add_wrap ? add_sum - BILLION : add_sum;
      sub_borrow = 32'(tod_ns) < mag_ns;
      sub_fix    = 32'(tod_ns) - mag_ns + (sub_borrow ? BILLION : 32'd0);
      // atomic load
      ld_fix = (32'(load_ns) >= BILLION) ? 32'(load_ns) - BILLION : 32'(load_ns);

      if (load_en) begin
         sec_nxt  = load_sec;
         ns_nxt   = ld_fix[NS_W-1:0];
         frac_nxt = '0;
      end else if (adj_en) begin
         frac_nxt = tod_frac;
         if (adj_neg) begin
            sec_nxt = tod_sec - SEC_W'(mag_big) - SEC_W'(sub_borrow);
            ns_nxt  = sub_fix[NS_W-1:0];
         end else begin
            sec_nxt = tod_sec + SEC_W'(mag_big) + SEC_W'(add_wrap);
            ns_nxt  = add_fix[NS_W-1:0];
         end
      end else begin
         sec_nxt  = tod_sec + SEC_W'(tick_wrap);
         ns_nxt   = ns_wrap[NS_W-1:0];
         frac_nxt = frac_sum[FRAC_W-1:0];
      end
   end

   logic unused_core;
   assign unused_core = ^{ns_wrap[31:NS_W], add_fix[31:NS_W], sub_fix[31:NS_W], ld_fix[31:NS_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tod_sec  <= '0;
         tod_ns   <= '0;
         tod_frac <= '0;
      end else begin
         tod_sec  <= sec_nxt;
         tod_ns   <= ns_nxt;
         tod_frac <= frac_nxt;
      end
   end
endmodule

// File: rtl/ptp_tod_capture.sv
`timescale 1ns/1ps
module ptp_tod_capture
   import ptp_tod_pkg::*;
#(
   parameter int unsigned N_CAP = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_CAP-1:0]           strobe,
   input  logic [31:0]                sec_lo,
   input  logic [NS_W-1:0]            ns,
   output logic [N_CAP-1:0][31:0]     cap_sec,
   output logic [N_CAP-1:0][NS_W-1:0] cap_ns
);
   for (genvar k = 0; k < N_CAP; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cap_sec[k] <= '0;
            cap_ns[k]  <= '0;
         end else if (strobe[k]) begin
            cap_sec[k] <= sec_lo;
            cap_ns[k]  <= ns;
         end
      end
   end
endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
   import ptp_tod_pkg::*;
#(
   parameter int unsigned SEC_W  = 48,
   parameter int unsigned INC_W  = 8,
   parameter int unsigned FRAC_W = 24,
   parameter int unsigned N_CAP  = 4,
   parameter logic [INC_W-1:0]  RST_INC_NS   = 4,
   parameter logic [FRAC_W-1:0] RST_INC_FRAC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [3:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [N_CAP-1:0]  cap_strobe
);
   localparam int unsigned SEC_HI_W = SEC_W - 32;

   if (SEC_W < 33 || SEC_W > 64) begin : g_bad_sec
      $error("SEC_W must be 33..64");
   end
   if (FRAC_W != 24) begin : g_bad_frac
      $error("FRAC_W must be 24 to match the scrambled layout");
   end
   if (INC_W < 1 || INC_W > 8) begin : g_bad_inc
      $error("INC_W must be 1..8");
   end
   if (N_CAP < 1 || N_CAP > 4) begin : g_bad_cap
      $error("N_CAP must be 1..4");
   end

   logic [INC_W-1:0]  inc_ns;
   logic [FRAC_W-1:0] inc_frac;
   logic [SEC_W-1:0]  tod_sec;
   logic [NS_W-1:0]   tod_ns;
   logic [FRAC_W-1:0] tod_frac;
   logic [N_CAP-1:0][31:0]     cap_sec;
   logic [N_CAP-1:0][NS_W-1:0] cap_ns;

   logic [SEC_HI_W-1:0] stage_hi, shadow_hi;
   logic [31:0]         stage_lo;
   logic [NS_W-1:0]     shadow_ns;
   logic [31:0]         rd_val;
   logic [1:0]          slot;

   wire wr_hit_ns  = bus_wr && bus_addr == A_NS;
   wire wr_hit_adj = bus_wr && bus_addr == A_ADJ;

   ptp_tod_incr #(
      .INC_W(INC_W), .FRAC_W(FRAC_W),
      .RST_INC_NS(RST_INC_NS), .RST_INC_FRAC(RST_INC_FRAC)
   ) u_incr (
      .clk(clk), .rst_n(rst_n),
      .wr_ns(bus_wr && bus_addr == A_INC_NS),
      .wr_sub(bus_wr && bus_addr == A_INC_SUB),
      .wdata(bus_wdata), .inc_ns(inc_ns), .inc_frac(inc_frac)
   );

   ptp_tod_core #(.SEC_W(SEC_W), .INC_W(INC_W), .FRAC_W(FRAC_W)) u_core (
      .clk(clk), .rst_n(rst_n), .inc_ns(inc_ns), .inc_frac(inc_frac),
      .load_en(wr_hit_ns), .load_sec({stage_hi, stage_lo}), .load_ns(bus_wdata[NS_W-1:0]),
      .adj_en(wr_hit_adj), .adj_neg(bus_wdata[31]), .adj_mag(bus_wdata[NS_W-1:0]),
      .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac)
   );

   ptp_tod_capture #(.N_CAP(N_CAP)) u_cap (
      .clk(clk), .rst_n(rst_n), .strobe(cap_strobe),
      .sec_lo(tod_sec[31:0]), .ns(tod_ns), .cap_sec(cap_sec), .cap_ns(cap_ns)
   );

   logic unused_top;
   assign unused_top = ^{bus_wdata[30], tod_frac};

   always_comb begin
      rd_val = '0;
      slot   = bus_addr[2:1];
      if (bus_addr[3]) begin
         if (32'(slot) < N_CAP)
            rd_val = bus_addr[0] ? 32'(cap_ns[slot]) : cap_sec[slot];
      end else begin
         case (bus_addr)
            A_INC_NS:  rd_val = 32'(inc_ns);
            A_INC_SUB: rd_val = sub_pack(inc_frac);
            A_SEC_HI:  rd_val = 32'(shadow_hi);
            A_SEC_LO:  rd_val = tod_sec[31:0];
            A_NS:      rd_val = 32'(shadow_ns);
            default:   rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_hi  <= '0;
         stage_lo  <= '0;
         shadow_hi <= '0;
         shadow_ns <= '0;
         bus_rdata <= '0;
      end else begin
         if (bus_wr && bus_addr == A_SEC_HI) stage_hi <= bus_wdata[SEC_HI_W-1:0];
         if (bus_wr && bus_addr == A_SEC_LO) stage_lo <= bus_wdata;
         if (bus_rd) begin
            bus_rdata <= rd_val;
            if (bus_addr == A_SEC_LO) begin
               shadow_hi <= tod_sec[SEC_W-1:32];
               shadow_ns <= tod_ns;
            end
         end
      end
   end
endmodule

// File: rtl/ptp_tod_checker.sv
`timescale 1ns/1ps
module ptp_tod_checker
   import ptp_tod_pkg::*;
#(
   parameter int unsigned SEC_W  = 48,
   parameter int unsigned INC_W  = 8,
   parameter int unsigned FRAC_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [3:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              strobe0,
   input logic [INC_W-1:0]  inc_ns,
   input logic [SEC_W-1:0]  tod_sec,
   input logic [NS_W-1:0]   tod_ns,
   input logic [FRAC_W-1:0] tod_frac,
   input logic [NS_W-1:0]   cap_ns0
);
   localparam logic [31:0] BILLION = 32'(NS_PER_SEC);
   logic [31:0] ns_peak;
   logic        time_write;
   assign ns_peak    = 32'(tod_ns) + 32'(inc_ns) + 32'd1;
   assign time_write = bus_wr && (bus_addr == A_NS || bus_addr == A_ADJ);

   AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tod_ns) < BILLION);  // R2

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!time_write && ns_peak < BILLION) |=>
         ((32'(tod_ns) - 32'($past(tod_ns)) == 32'($past(inc_ns))) ||
          (32'(tod_ns) - 32'($past(tod_ns)) == 32'($past(inc_ns)) + 32'd1)) && $stable(tod_sec));  // R1

   AST_STAGE_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == A_SEC_HI || bus_addr == A_SEC_LO)) |=>
         (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + SEC_W'(1)));  // R5

   AST_LOAD_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_NS && 32'(bus_wdata[NS_W-1:0]) < BILLION) |=>
         (tod_ns == $past(bus_wdata[NS_W-1:0]) && tod_frac == '0));  // R6

   AST_ADJ_FRAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_ADJ) |=> $stable(tod_frac));  // R8

   AST_CAPTURE_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
      strobe0 |=> cap_ns0 == $past(tod_ns));  // R9
endmodule

bind ptp_tod_counter ptp_tod_checker #(.SEC_W(SEC_W), .INC_W(INC_W), .FRAC_W(FRAC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .strobe0(cap_strobe[0]), .inc_ns(inc_ns), .tod_sec(tod_sec), .tod_ns(tod_ns),
   .tod_frac(tod_frac), .cap_ns0(cap_ns[0])
);

// File: tb/sim_ptp_tod_counter.sv
`timescale 1ns/1ps
module sim_ptp_tod_counter;
   localparam longint unsigned BIL = 64'd1_000_000_000;

   logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr  = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  cap_strobe = '0;
   wire  [31:0] bus_rdata;
   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   ptp_tod_counter u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_strobe(cap_strobe)
   );

   // reference model, updated at each rising edge from stable inputs
   logic [47:0] m_sec;
   logic [29:0] m_ns, m_shns;
   logic [23:0] m_frac, m_incf;
   logic [7:0]  m_inc;
   logic [15:0] m_sthi, m_shhi;
   logic [31:0] m_stlo, exp_rdata;
   logic [31:0] m_csec [4];
   logic [29:0] m_cns  [4];

   function automatic logic [31:0] pack_sub(input logic [23:0] f);
      return {f[7:0], 8'h00, f[23:8]};
   endfunction

   always @(posedge clk) begin : mdl
      longint unsigned t, whole, part, fs;
      if (!rst_n) begin
         m_sec = '0; m_ns = '0; m_frac = '0; m_inc = 8'd4; m_incf = '0;
         m_sthi = '0; m_stlo = '0; m_shhi = '0; m_shns = '0; exp_rdata = '0;
         for (int k = 0; k < 4; k++) begin m_csec[k] = '0; m_cns[k] = '0; end
      end else begin
         if (bus_rd) begin
            if (bus_addr[3]) exp_rdata = bus_addr[0] ? {2'b0, m_cns[bus_addr[2:1]]} : m_csec[bus_addr[2:1]];
            else case (bus_addr)
               4'd0: exp_rdata = {24'b0, m_inc};
               4'd1: exp_rdata = pack_sub(m_incf);
               4'd2: exp_rdata = {16'b0, m_shhi};
               4'd3: begin exp_rdata = m_sec[31:0]; m_shhi = m_sec[47:32]; m_shns = m_ns; end
               4'd4: exp_rdata = {2'b0, m_shns};
               default: exp_rdata = '0;
            endcase
         end
         for (int k = 0; k < 4; k++)
            if (cap_strobe[k]) begin m_csec[k] = m_sec[31:0]; m_cns[k] = m_ns; end
         if (bus_wr && bus_addr == 4'd4) begin
            t = longint'(bus_wdata[29:0]);
            m_sec = {m_sthi, m_stlo}; m_ns = 30'(t % BIL); m_frac = '0;
         end else if (bus_wr && bus_addr == 4'd5) begin
            whole = longint'(bus_wdata[29:0]) / BIL;
            part  = longint'(bus_wdata[29:0]) % BIL;
            if (bus_wdata[31]) begin
               if (longint'(m_ns) >= part) m_ns = 30'(longint'(m_ns) - part);
               else begin m_ns = 30'(longint'(m_ns) + BIL - part); whole = whole + 1; end
               m_sec = m_sec - 48'(whole);
            end else begin
               t = longint'(m_ns) + part;
               if (t >= BIL) begin t = t - BIL; whole = whole + 1; end
               m_ns = 30'(t); m_sec = m_sec + 48'(whole);
            end
         end else begin
            fs = longint'(m_frac) + longint'(m_incf);
            t  = longint'(m_ns) + longint'(m_inc) + (fs >> 24);
            m_frac = 24'(fs);
            if (t >= BIL) begin t = t - BIL; m_sec = m_sec + 48'd1; end
            m_ns = 30'(t);
         end
         if (bus_wr) case (bus_addr)
            4'd0: m_inc  = bus_wdata[7:0];
            4'd1: m_incf = {bus_wdata[15:0], bus_wdata[31:24]};
            4'd2: m_sthi = bus_wdata[15:0];
            4'd3: m_stlo = bus_wdata;
            default: ;
         endcase
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input string req);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, bus_rdata, exp_rdata);
   endtask

   task automatic set_time(input logic [15:0] hi, input logic [31:0] lo, input logic [31:0] ns);
      wr(4'd2, {16'h0, hi});
      wr(4'd3, lo);
      wr(4'd4, ns);
   endtask

   task automatic snapshot(input string req);
      rd(4'd3, req);
      repeat ($urandom_range(0, 6)) @(negedge clk);
      rd(4'd2, req);
      rd(4'd4, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(1588));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R4 reset state
      rd(4'd0, "R4"); chk("R4 step reset", bus_rdata, 32'd4);
      rd(4'd1, "R4"); chk("R4 frac reset", bus_rdata, 32'd0);
      // R10 unmapped words
      rd(4'd6, "R10"); chk("R10 hole", bus_rdata, 32'd0);
      rd(4'd7, "R10");

      // R3 scrambled layout
      wr(4'd1, 32'hA5FF_1234);
      rd(4'd1, "R3"); chk("R3 packing", bus_rdata, 32'hA500_1234);

      // R5 staging, R6 atomic load
      wr(4'd1, 32'h0);
      wr(4'd2, 32'h0000_00AB);
      wr(4'd3, 32'h1234_5678);
      repeat (3) @(negedge clk);
      rd(4'd3, "R5"); chk("R5 staged not live", {31'b0, bus_rdata == 32'h1234_5678}, 32'd0);
      wr(4'd4, 32'd999_999_990);
      rd(4'd3, "R6"); chk("R6 load sec", bus_rdata, 32'h1234_5678);
      rd(4'd2, "R6"); chk("R6 load hi", bus_rdata, 32'h0000_00AB);
      rd(4'd4, "R6"); chk("R6 load ns", bus_rdata, 32'd999_999_990);
      repeat (4) @(negedge clk);
      snapshot("R2");

      // R6 oversize nanoseconds
      set_time(16'h0, 32'd7, 32'h3FFF_FFFF);
      rd(4'd3, "R6");
      rd(4'd4, "R6"); chk("R6 fold", bus_rdata, 32'd73_741_823);

      // R2 48-bit seconds wrap
      set_time(16'hFFFF, 32'hFFFF_FFFF, 32'd999_999_999);
      rd(4'd3, "R2"); chk("R2 pre wrap", bus_rdata, 32'hFFFF_FFFF);
      rd(4'd3, "R2"); chk("R2 wrap lo", bus_rdata, 32'd0);
      rd(4'd2, "R2"); chk("R2 wrap hi", bus_rdata, 32'd0);

      // R8 negative offset above one second with borrow
      set_time(16'h0, 32'd10, 32'd100);
      wr(4'd5, 32'h8000_0000 | 32'd1_000_000_200);
      rd(4'd3, "R8"); chk("R8 neg sec", bus_rdata, 32'd8);
      rd(4'd4, "R8"); chk("R8 neg ns", bus_rdata, 32'd999_999_900);
      wr(4'd5, 32'd1_000_000_150);
      snapshot("R8");
      wr(4'd5, 32'h8000_0000 | 32'd50);
      snapshot("R8");

      // R1 fractional carry: step 1 ns + 0.5 ns
      wr(4'd0, 32'd1);
      wr(4'd1, 32'h0000_8000);
      set_time(16'h0, 32'd0, 32'd0);
      repeat (10) @(negedge clk);
      rd(4'd3, "R1"); chk("R1 sec", bus_rdata, 32'd0);
      rd(4'd4, "R1"); chk("R1 ns", bus_rdata, 32'd15);

      // R7 shadow holds while time runs
      wr(4'd0, 32'd200);
      rd(4'd3, "R7");
      repeat (20) @(negedge clk);
      rd(4'd4, "R7");
      rd(4'd2, "R7");

      // R9 capture slots
      for (int k = 0; k < 4; k++) begin
         cap_strobe = 4'(1 << k);
         @(negedge clk);
         cap_strobe = '0;
         repeat (k + 2) @(negedge clk);
      end
      for (int k = 0; k < 8; k++) rd(4'(8 + k), "R9");

      // random mix
      for (int it = 0; it < 400; it++) begin
         case ($urandom_range(0, 6))
            0: wr(4'd0, $urandom);
            1: wr(4'd1, $urandom);
            2: set_time(16'($urandom), $urandom,
                        ($urandom_range(0, 3) == 0) ? $urandom & 32'h3FFF_FFFF : 32'(999_999_000 + $urandom_range(0, 999)));
            3: wr(4'd5, $urandom);
            4: begin
                  cap_strobe = 4'($urandom);
                  @(negedge clk);
                  cap_strobe = '0;
                  rd(4'(8 + $urandom_range(0, 7)), "R9");
               end
            5: snapshot("R1");
            default: repeat ($urandom_range(1, 20)) @(negedge clk);
         endcase
         rd(4'($urandom_range(0, 15)), "R10");
      end
      snapshot("R2");

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule